// File: doc/BRIEF.md
# Single-Clock FIFO with Coarse Fill Level

This block is a first-in first-out buffer in which writes and reads share one clock. A producer pushes words while the `full` flag is low. A consumer pops words while the `empty` flag is low, and each popped word appears on `rd_data` one clock after the request. Requests made against the wrong flag are dropped. Nothing in the buffer changes because of them.

Alongside the flags, the block drives a fill indicator of `LVL_W` bits. It is the upper slice of the true occupancy: the low bits are cut away, so each step of `level` covers `DEPTH / 2**LVL_W` words. With eight entries and a two-bit level, each step is one quarter of the buffer. When the buffer is completely full, `level` reads all ones. `level` moves on the same rising edge that accepts the access causing the change. A consumer can use it as a cheap near-full or near-empty hint without comparing the whole count.

Top module: `cc_fifo`

## Requirements
- R1: While `rst_n` is low, and on the first sampled cycle after it rises, `empty` is 1, `full` is 0, `level` is 0 and `rd_data` is 0.
- R2: A write is accepted only when `full` is 0. A write request while `full` is 1 does not change the flags or `level`, and the word is not stored, so it never comes out of the buffer.
- R3: A read is accepted only when `empty` is 0. A read request while `empty` is 1 leaves `rd_data`, `level` and the flags unchanged.
- R4: Accepted words leave in the order they were accepted. `rd_data` takes the oldest word on the edge that accepts the read, and holds its value on every other edge.
- R5: `level` equals the stored word count shifted right by `log2(DEPTH) - LVL_W` bits, so the low-order count bits are dropped. When the count equals `DEPTH`, `level` is all ones. With `DEPTH`=8 and `LVL_W`=2, counts 0..8 give levels 0,0,1,1,2,2,3,3,3.
- R6: `level`, `full` and `empty` reflect an accepted access immediately after the rising edge that accepts it, with no extra cycle of delay.
- R7: An accepted read and an accepted write on the same edge leave the word count unchanged. When the buffer is empty, a simultaneous request stores only the write. When the buffer is full, a simultaneous request performs only the read.
- R8: `full` is 1 exactly when `DEPTH` words are stored, and `empty` is 1 exactly when none are stored. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free entry |
| rd_req | input | 1 | Read request |
| rd_data | output | DATA_W | Last word popped |
| empty | output | 1 | No stored word |
| level | output | LVL_W | Coarse occupancy, low bits dropped |

## Verification
The properties assume that `DEPTH` is a power of two and that `LVL_W` lies between 1 and `log2(DEPTH)`. They place no restriction on the request inputs, because requests made against a raised flag are part of the behaviour being checked. The stimulus runs the default eight-entry, two-bit configuration. It deliberately drives requests into a full and an empty buffer, and holds every request stable from the falling edge through the next rising edge.

// File: rtl/cc_fifo.sv
module cc_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic [LVL_W-1:0]  level
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]       wp, rp, occ;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_ok, rd_ok;

  assign wr_ok = wr_req & ~full;
  assign rd_ok = rd_req & ~empty;
  assign occ   = wp - rp;
  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign level = full ? {LVL_W{1'b1}} : occ[AW-1 -: LVL_W];

  always_ff @(posedge clk)
    if (wr_ok) mem[wp[AW-1:0]] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      rd_data <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) begin
        rp      <= rp + 1'b1;
        rd_data <= mem[rp[AW-1:0]];
      end
    end
  end
endmodule

// File: rtl/cc_fifo_chk.sv
module cc_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_req,
  input logic              rd_req,
  input logic              full,
  input logic              empty,
  input logic [DATA_W-1:0] rd_data,
  input logic [LVL_W-1:0]  level
);
  always @(posedge clk)
    if (!rst_n)
      a_r1_reset_clear: assert (empty && !full && level == '0);

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r5_full_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> level == {LVL_W{1'b1}});

  a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> level == '0);

  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_req && !rd_req |=> full && $stable(level));

  a_r3_empty_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_req && !wr_req |=> empty && $stable(rd_data) && $stable(level));

  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && !empty) |=> $stable(rd_data));

  a_r7_both_stable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && rd_req && !full && !empty |=> $stable(level) && !full && !empty);

  a_r6_write_shows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !rd_req && empty |=> !empty);
endmodule

bind cc_fifo cc_fifo_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
  .full(full), .empty(empty), .rd_data(rd_data), .level(level)
);

// File: tb/sim_cc_fifo.sv
`timescale 1ns/1ps
module sim_cc_fifo;
  localparam int DW = 8, DEPTH = 8, LW = 2, SH = 1;

  logic clk = 0, rst_n;
  logic wr_req = 0, rd_req = 0;
  logic [DW-1:0] wr_data = 0, rd_data;
  logic full, empty;
  logic [LW-1:0] level;

  int checks = 0, errors = 0, cnt = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] last_rd = 0;
  bit mon_go = 0;

  cc_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .LVL_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data), .full(full),
    .rd_req(rd_req), .rd_data(rd_data), .empty(empty), .level(level));

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] lvl_exp(int c);
    return (c == DEPTH) ? {LW{1'b1}} : LW'(c >> SH);
  endfunction

  always begin
    @(posedge clk); #1;
    if (mon_go) begin
      logic [DW-1:0] e;
      e = q.pop_front();
      chk("R4 order", rd_data, e);
      last_rd = e;
      mon_go = 0;
    end else if (rst_n === 1'b1) chk("R3/R4 hold", rd_data, last_rd);
  end

  task automatic step(bit w, bit r, logic [DW-1:0] d, string tag);
    bit aw, ar;
    @(negedge clk);
    wr_req = w; rd_req = r; wr_data = d;
    aw = w && cnt < DEPTH;
    ar = r && cnt > 0;
    if (ar) mon_go = 1;
    if (aw) q.push_back(d);
    cnt = cnt + int'(aw) - int'(ar);
    @(posedge clk); #1;
    chk({tag, " R5/R6 level"}, level, lvl_exp(cnt));
    chk({tag, " R8 full"}, full, cnt == DEPTH);
    chk({tag, " R8 empty"}, empty, cnt == 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_req = 0; rd_req = 0;
    q.delete(); cnt = 0; last_rd = 0; mon_go = 0;
    #1;
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 level", level, 0); chk("R1 rd_data", rd_data, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 level after", level, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    do_reset();
    step(0, 1, 0, "R3 read empty");
    for (int i = 0; i < DEPTH; i++) step(1, 0, DW'(8'h10 + i), "R5 fill");
    step(1, 0, 8'hEE, "R2 write full");
    step(1, 1, 8'hEF, "R7 both full");
    step(1, 0, 8'h30, "R2 refill");
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, "R4 drain");
    step(0, 1, 0, "R3 read empty");
    step(1, 1, 8'h41, "R7 both empty");
    step(1, 0, 8'h42, "R6 write");
    step(1, 1, 8'h43, "R7 both mid");
    step(1, 1, 8'h44, "R7 both mid");
    for (int i = 0; i < 400; i++) step(1'($urandom), 1'($urandom), DW'($urandom), "mix");
    do_reset();
    step(1, 0, 8'h55, "R6 after reset");
    step(0, 1, 0, "R4 after reset");
    @(posedge clk); #2;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule